// File: doc/BRIEF.md
# Length-Parsing Response Drain Engine

This block is the requesting side of a byte-wide device data FIFO. After a command has been issued, `start` launches a drain of the device's answer into a local buffer that holds `BUF_BYTES` bytes. The engine talks to the device over a single-transaction register bus: 32-bit status reads, byte reads from the data FIFO, and one 32-bit status write. Each transaction is held until the device acknowledges it. Every byte that arrives is written straight out through a byte-wide buffer write port. The write address equals the byte's position in the response.

The length of the answer is not known at the start. The engine begins by assuming the whole buffer may be filled. Once the sixth byte has arrived, it replaces that assumption with the 32-bit big-endian length carried in bytes 2 to 5 of the header, after a bounds check. Reads proceed in bursts whose size the device advertises in its status word. Between bursts the engine re-polls status. When the response ends, the engine confirms that the FIFO is empty and then tells the device it is ready for the next command. A one-cycle `done` pulse reports a result code and the number of bytes drained.

Top module: `resp_drain`

## Requirements
- R1: After `start`, the engine reads status (`dev_sel`=0) until status bit 7 (valid) and bit 4 (data available) are both 1. If `POLL_LIMIT` consecutive status reads fail this test, it ends with code 1 (timeout) and a count of 0.
- R2: Data reads (`dev_sel`=1) start only after such a status. Within one burst, the number of data reads never exceeds the burst count in status bits 23:8 of the status read that opened the burst.
- R3: Every data byte received is written to the buffer in arrival order, at address 0, 1, 2, ... (the byte's offset).
- R4: When the sixth byte has been read, the expected length becomes byte2<<24 | byte3<<16 | byte4<<8 | byte5. If this value is below 6 or above `BUF_BYTES`, the engine makes no further reads and ends with code 3 (no space) and a count of 6.
- R5: Before the length is known, the expected length is `BUF_BYTES`. The engine never reads more bytes than the expected length.
- R6: If a status read inside the burst loop reports a burst count of 0, the engine reads status again. After `POLL_LIMIT` consecutive zero counts it ends with code 2 (I/O error).
- R7: After each burst the engine polls status until valid is 1. If `POLL_LIMIT` consecutive polls show valid at 0, it ends with code 1 (timeout).
- R8: If the offset equals the expected length and the valid status still shows data available, the engine ends with code 3'd4 (bad message) and does not write status.
- R9: On success the engine writes 32'h40 to status (`dev_we`=1, `dev_sel`=0) exactly once. It then ends with code 0, and `rx_count` equals the number of bytes read.
- R10: If a valid status after a burst shows no data available before the expected length is reached, the response is accepted as short. The outcome is code 0 with the bytes read so far.
- R11: `busy` is 1 from the cycle after `start` until completion. `done` is a single-cycle pulse, and `dev_req`, once raised, stays high with a stable selector until `dev_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin draining one response (taken when idle) |
| busy | output | 1 | Engine active |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 no space, 4 bad message |
| rx_count | output | 7 | Bytes drained (valid with `done`) |
| dev_req | output | 1 | Device transaction pending |
| dev_we | output | 1 | 1 = status write, 0 = read |
| dev_sel | output | 1 | 0 = status register, 1 = data FIFO |
| dev_wdata | output | 32 | Status write value |
| dev_rdata | input | 32 | Read data, valid with `dev_ack` |
| dev_ack | input | 1 | Transaction complete (one cycle) |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 6 | Buffer byte address (= offset) |
| buf_wdata | output | 8 | Buffer byte |

## Verification
The assertions rely on the device acknowledging only while `dev_req` is high, with at most one acknowledge per request, and on `start` arriving only while the engine is idle. The bench's device model acknowledges once per observed request after a random delay of zero to two cycles, and it pulses `start` only between runs. The model also caps consecutive zero burst counts well below the poll limit, except in the one run that deliberately stalls. In that way the error paths are entered only when a case asks for them.

// File: rtl/resp_drain_pkg.sv
package resp_drain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_BURST_CHK,
    ST_REREAD,
    ST_DATA,
    ST_LEN_CHK,
    ST_POLL_VALID,
    ST_CMD_RDY
  } drain_state_e;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_TIMEOUT = 3'd1,
    RC_IO      = 3'd2,
    RC_NOSPACE = 3'd3,
    RC_BADMSG  = 3'd4
  } drain_code_e;

  localparam int          STS_VALID_BIT = 7;
  localparam int          STS_AVAIL_BIT = 4;
  localparam int          STS_BURST_LSB = 8;
  localparam int          BURST_W       = 16;
  localparam logic [31:0] CMD_READY_WORD = 32'h0000_0040;
  localparam logic        SEL_STATUS    = 1'b0;
  localparam logic        SEL_DATA      = 1'b1;
  localparam int          HDR_BYTES     = 6;
  localparam int          LEN_FIRST     = 2;
  localparam int          LEN_LAST      = 5;

endpackage

// File: rtl/resp_bus_port.sv
module resp_bus_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_we,
  input  logic        go_sel,
  input  logic [31:0] go_wdata,
  input  logic        ack,
  output logic        req,
  output logic        we,
  output logic        sel,
  output logic [31:0] wdata
);

  logic        req_q, req_d;
  logic        we_q, sel_q;
  logic [31:0] wdata_q;
  logic        load;

  always_comb begin
    req_d = req_q;
    load  = 1'b0;
    if (req_q && ack) begin
      req_d = 1'b0;
    end else if (!req_q && go) begin
      req_d = 1'b1;
      load  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      sel_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      req_q <= req_d;
      if (load) begin
        we_q    <= go_we;
        sel_q   <= go_sel;
        wdata_q <= go_wdata;
      end
    end
  end

  assign req   = req_q;
  assign we    = we_q;
  assign sel   = sel_q;
  assign wdata = wdata_q;

  // R11: a pending transaction is held unchanged until acknowledged
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> (req_q && $stable(sel_q) && $stable(we_q)));

endmodule

// File: rtl/resp_poll_timer.sv
module resp_poll_timer #(
  parameter int POLL_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic at_limit
);

  localparam int W = $clog2(POLL_LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (miss) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || miss) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == W'(POLL_LIMIT - 1));

  // R6: the miss counter never runs past its limit
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < W'(POLL_LIMIT));

endmodule

// File: rtl/resp_len_capture.sv
module resp_len_capture #(
  parameter int BUF_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        shift_en,
  input  logic [7:0]  byte_in,
  output logic [31:0] len_val,
  output logic        too_small,
  output logic        too_big
);

  import resp_drain_pkg::*;

  logic [31:0] len_q, len_d;

  always_comb begin
    len_d = len_q;
    if (clr)           len_d = '0;
    else if (shift_en) len_d = {len_q[23:0], byte_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (clr || shift_en) len_q <= len_d;
  end

  assign len_val   = len_q;
  assign too_small = len_q < 32'(HDR_BYTES);
  assign too_big   = len_q > 32'(BUF_BYTES);

endmodule

// File: rtl/resp_drain.sv
module resp_drain #(
  parameter int BUF_BYTES  = 64,
  parameter int POLL_LIMIT = 1024,
  localparam int CW = $clog2(BUF_BYTES + 1),
  localparam int AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [2:0]    err_code,
  output logic [CW-1:0] rx_count,
  output logic          dev_req,
  output logic          dev_we,
  output logic          dev_sel,
  output logic [31:0]   dev_wdata,
  input  logic [31:0]   dev_rdata,
  input  logic          dev_ack,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wdata
);

  import resp_drain_pkg::*;

  drain_state_e         state_q, state_d;
  logic [CW-1:0]        off_q, off_d;
  logic [CW-1:0]        exp_q, exp_d;
  logic [BURST_W-1:0]   burst_q, burst_d;
  logic                 done_q, done_d;
  logic [2:0]           code_q, code_d;
  logic [CW-1:0]        count_q, count_d;

  logic                 go, go_we, go_sel;
  logic                 port_busy;
  logic                 tmr_clr, tmr_miss, tmr_at_limit;
  logic                 cap_clr, cap_en;
  logic [31:0]          len_val;
  logic                 len_small, len_big;
  logic                 fin;
  drain_code_e          fin_code;

  logic                 sts_valid, sts_avail;
  logic [BURST_W-1:0]   sts_burst;

  assign sts_valid = dev_rdata[STS_VALID_BIT];
  assign sts_avail = dev_rdata[STS_AVAIL_BIT];
  assign sts_burst = dev_rdata[STS_BURST_LSB +: BURST_W];

  resp_bus_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .go_we    (go_we),
    .go_sel   (go_sel),
    .go_wdata (CMD_READY_WORD),
    .ack      (dev_ack),
    .req      (port_busy),
    .we       (dev_we),
    .sel      (dev_sel),
    .wdata    (dev_wdata)
  );

  resp_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .miss     (tmr_miss),
    .at_limit (tmr_at_limit)
  );

  resp_len_capture #(.BUF_BYTES(BUF_BYTES)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cap_clr),
    .shift_en  (cap_en),
    .byte_in   (dev_rdata[7:0]),
    .len_val   (len_val),
    .too_small (len_small),
    .too_big   (len_big)
  );

  always_comb begin
    state_d  = state_q;
    off_d    = off_q;
    exp_d    = exp_q;
    burst_d  = burst_q;
    done_d   = 1'b0;
    code_d   = code_q;
    count_d  = count_q;
    go       = 1'b0;
    go_we    = 1'b0;
    go_sel   = SEL_STATUS;
    tmr_clr  = 1'b0;
    tmr_miss = 1'b0;
    cap_clr  = 1'b0;
    cap_en   = 1'b0;
    fin      = 1'b0;
    fin_code = RC_OK;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          off_d   = '0;
          exp_d   = CW'(BUF_BYTES);
          tmr_clr = 1'b1;
          cap_clr = 1'b1;
          state_d = ST_WAIT_RDY;
        end
      end

      ST_WAIT_RDY: begin
        go = !port_busy;
        if (dev_ack) begin
          if (sts_valid && sts_avail) begin
            burst_d = sts_burst;
            tmr_clr = 1'b1;
            state_d = ST_BURST_CHK;
          end else if (tmr_at_limit) begin
            fin      = 1'b1;
            fin_code = RC_TIMEOUT;
          end else begin
            tmr_miss = 1'b1;
          end
        end
      end

      ST_BURST_CHK: begin
        tmr_clr = 1'b1;
        state_d = (burst_q == '0) ? ST_REREAD : ST_DATA;
      end

      ST_REREAD: begin
        go = !port_busy;
        if (dev_ack) begin
          burst_d = sts_burst;
          if (sts_burst != '0) begin
            tmr_clr = 1'b1;
            state_d = ST_DATA;
          end else if (tmr_at_limit) begin
            fin      = 1'b1;
            fin_code = RC_IO;
          end else begin
            tmr_miss = 1'b1;
          end
        end
      end

      ST_DATA: begin
        if ((burst_q != '0) && (off_q < exp_q)) begin
          go     = !port_busy;
          go_sel = SEL_DATA;
          if (dev_ack) begin
            off_d   = off_q + CW'(1);
            burst_d = burst_q - BURST_W'(1);
            cap_en  = (off_q >= CW'(LEN_FIRST)) && (off_q <= CW'(LEN_LAST));
            if (off_q == CW'(HDR_BYTES - 1)) state_d = ST_LEN_CHK;
          end
        end else begin
          tmr_clr = 1'b1;
          state_d = ST_POLL_VALID;
        end
      end

      ST_LEN_CHK: begin
        if (len_small || len_big) begin
          fin      = 1'b1;
          fin_code = RC_NOSPACE;
        end else begin
          exp_d   = len_val[CW-1:0];
          state_d = ST_DATA;
        end
      end

      ST_POLL_VALID: begin
        go = !port_busy;
        if (dev_ack) begin
          if (!sts_valid) begin
            if (tmr_at_limit) begin
              fin      = 1'b1;
              fin_code = RC_TIMEOUT;
            end else begin
              tmr_miss = 1'b1;
            end
          end else if (off_q == exp_q) begin
            if (sts_avail) begin
              fin      = 1'b1;
              fin_code = RC_BADMSG;
            end else begin
              state_d = ST_CMD_RDY;
            end
          end else if (sts_avail) begin
            burst_d = sts_burst;
            state_d = ST_BURST_CHK;
          end else begin
            state_d = ST_CMD_RDY;
          end
        end
      end

      ST_CMD_RDY: begin
        go    = !port_busy;
        go_we = 1'b1;
        if (dev_ack) begin
          fin      = 1'b1;
          fin_code = RC_OK;
        end
      end

      default: state_d = ST_IDLE;
    endcase

    if (fin) begin
      done_d  = 1'b1;
      code_d  = fin_code;
      count_d = off_q;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      exp_q   <= CW'(BUF_BYTES);
      burst_q <= '0;
      done_q  <= 1'b0;
      code_q  <= '0;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      exp_q   <= exp_d;
      burst_q <= burst_d;
      done_q  <= done_d;
      if (fin) begin
        code_q  <= code_d;
        count_q <= count_d;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err_code  = code_q;
  assign rx_count  = count_q;
  assign dev_req   = port_busy;
  assign buf_we    = (state_q == ST_DATA) && dev_ack;
  assign buf_addr  = off_q[AW-1:0];
  assign buf_wdata = dev_rdata[7:0];

  // R3 / R5: buffer writes stay inside the buffer
  a_r3_addr_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (off_q < CW'(BUF_BYTES)));

  // R5: the read offset never passes the expected length
  a_r5_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= exp_q);

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the only write ever issued is the command-ready word to status
  a_r9_cmd_word: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_we) |-> (dev_wdata == CMD_READY_WORD && dev_sel == SEL_STATUS));

  // R4: a rejected length is reported after exactly the header bytes
  a_r4_nospace_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'(RC_NOSPACE)) |-> (rx_count == CW'(HDR_BYTES)));

  // R2: a data read is launched only with burst credit left
  a_r2_burst_credit: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_req) && dev_sel == SEL_DATA) |-> ($past(burst_q) != '0));

endmodule

// File: tb/resp_drain_bench.sv
module resp_drain_bench;

  localparam int L    = 20;
  localparam int PL   = 12;
  localparam int CW   = $clog2(L + 1);
  localparam int AW   = $clog2(L);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done;
  logic [2:0]    err_code;
  logic [CW-1:0] rx_count;
  logic          dev_req, dev_we, dev_sel;
  logic [31:0]   dev_wdata;
  logic [31:0]   dev_rdata;
  logic          dev_ack;
  logic          buf_we;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_wdata;

  always #5 clk = ~clk;

  resp_drain #(.BUF_BYTES(L), .POLL_LIMIT(PL)) u_resp_drain (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err_code(err_code), .rx_count(rx_count),
    .dev_req(dev_req), .dev_we(dev_we), .dev_sel(dev_sel), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_ack(dev_ack),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // device model state
  logic [7:0]  resp [0:31];
  int          total, consumed, nready, stall_run, io_at, drop_at;
  bit          stalls_on;
  int          cr_writes;
  logic [31:0] last_wr;

  // buffer capture
  logic [7:0]  cap [0:31];
  int          wr_total = 0;
  int          order_errs = 0;
  int          base = 0;

  always @(posedge clk) begin
    if (buf_we) begin
      if (int'(buf_addr) != wr_total - base) order_errs <= order_errs + 1;
      cap[buf_addr] <= buf_wdata;
      wr_total <= wr_total + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] status_word();
    int rem, b;
    logic [31:0] st;
    if (drop_at >= 0 && consumed >= drop_at) return 32'h0;
    if (nready > 0) begin
      nready = nready - 1;
      return 32'h80;
    end
    rem = total - consumed;
    b = 1 + int'($urandom % 4);
    if (rem < b) b = rem;
    if (io_at >= 0 && consumed >= io_at) b = 0;
    else if (stalls_on && stall_run < 2 && ($urandom % 4) == 0) begin
      b = 0;
      stall_run = stall_run + 1;
    end else stall_run = 0;
    st = 32'h80 | ((rem > 0) ? 32'h10 : 32'h0) | (32'(b) << 8);
    return st;
  endfunction

  initial begin
    dev_ack = 1'b0;
    dev_rdata = '0;
    forever begin
      @(negedge clk);
      if (dev_req) begin
        repeat (int'($urandom % 3)) @(negedge clk);
        if (dev_we) begin
          cr_writes = cr_writes + 1;
          last_wr = dev_wdata;
          dev_rdata = '0;
        end else if (dev_sel) begin
          dev_rdata = (consumed < total) ? {24'h0, resp[consumed]} : 32'hEE;
          consumed = consumed + 1;
        end else begin
          dev_rdata = status_word();
        end
        dev_ack = 1'b1;
        @(negedge clk);
        dev_ack = 1'b0;
      end
    end
  end

  // expected outcome from the requirements
  function automatic void predict(input int tot, input int f, output int code, output int cnt);
    if (tot == 0) begin code = 1; cnt = 0; end
    else if (L < 6) begin cnt = (tot < L) ? tot : L; code = (tot > L) ? 4 : 0; end
    else if (tot < 6) begin code = 0; cnt = tot; end
    else if (f < 6 || f > L) begin code = 3; cnt = 6; end
    else if (tot < f) begin code = 0; cnt = tot; end
    else if (tot > f) begin code = 4; cnt = f; end
    else begin code = 0; cnt = f; end
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int tot, input logic [31:0] f, input int nrdy, input bit stl,
                          input int io, input int drop, input int force_code, input string req);
    int ecode, ecnt, k, o0;
    for (int i = 0; i < 32; i++) resp[i] = 8'($urandom);
    resp[2] = f[31:24]; resp[3] = f[23:16]; resp[4] = f[15:8]; resp[5] = f[7:0];
    total = tot; consumed = 0; nready = nrdy; stall_run = 0; stalls_on = stl;
    io_at = io; drop_at = drop; cr_writes = 0; last_wr = '0;
    base = wr_total; o0 = order_errs;
    if (force_code >= 0) begin ecode = force_code; ecnt = -1; end
    else predict(tot, (f > 32'd1000) ? 1000 : int'(f), ecode, ecnt);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (!done && k < 4000) begin @(negedge clk); k++; end
    check(done == 1'b1, {req, " done seen"}, int'(done), 1);
    check(int'(err_code) == ecode, {req, " code"}, int'(err_code), ecode);
    if (ecnt >= 0) begin
      check(int'(rx_count) == ecnt, {req, " count"}, int'(rx_count), ecnt);
      for (int i = 0; i < ecnt; i++)
        if (cap[i] !== resp[i]) check(1'b0, "R3 buffer byte", int'(cap[i]), int'(resp[i]));
      check(wr_total - base == ecnt, "R3 buffer writes", wr_total - base, ecnt);
    end
    check(order_errs == o0, "R3 write order", order_errs - o0, 0);
    check(cr_writes == ((ecode == 0) ? 1 : 0), "R9 command-ready writes", cr_writes,
          (ecode == 0) ? 1 : 0);
    if (ecode == 0) check(last_wr == 32'h40, "R9 write value", int'(last_wr), 32'h40);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R11 back to idle", int'({busy, done}), 0);
  endtask

  initial begin
    int t, fsel;
    logic [31:0] f;
    void'($urandom(32'd4242));
    total = 0; consumed = 0; nready = 0; stall_run = 0; io_at = -1; drop_at = -1;
    stalls_on = 0; cr_writes = 0; last_wr = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && dev_req == 0 && buf_we == 0, "R11 reset state",
          int'({busy, done, dev_req, buf_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 busy follows start
    total = 10; consumed = 0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", int'(busy), 1);
    while (!done) @(negedge clk);
    @(negedge clk);

    run_case(0, 32'd10, 0, 0, -1, -1, -1, "R1 never ready");
    run_case(10, 32'd10, 3, 0, -1, -1, -1, "R1 R5 exact length");
    run_case(12, 32'd10, 0, 1, -1, -1, -1, "R8 leftover data");
    run_case(8, 32'd10, 0, 1, -1, -1, -1, "R10 short response");
    run_case(4, 32'd10, 1, 0, -1, -1, -1, "R10 under header");
    run_case(10, 32'd5, 0, 0, -1, -1, -1, "R4 length too small");
    run_case(22, 32'd21, 0, 0, -1, -1, -1, "R4 length too big");
    run_case(12, 32'h0001_0008, 0, 0, -1, -1, -1, "R4 big-endian upper bytes");
    run_case(20, 32'd20, 0, 1, -1, -1, -1, "R4 R5 length equals capacity");
    run_case(6, 32'd6, 0, 0, -1, -1, -1, "R4 header-only response");
    run_case(15, 32'd15, 0, 0, 7, -1, 2, "R6 burst stuck at zero");
    run_case(15, 32'd15, 0, 0, -1, 3, 1, "R7 valid lost");
    run_case(24, 32'd18, 2, 1, -1, -1, -1, "R2 R5 bursts with stalls");

    for (int n = 0; n < 30; n++) begin
      t = int'($urandom % 25);
      fsel = int'($urandom % 4);
      case (fsel)
        0: f = 32'(t);
        1: f = 32'(t + 2);
        2: f = (t >= 2) ? 32'(t - 2) : 32'(0);
        default: f = 32'($urandom % 30);
      endcase
      run_case(t, f, int'($urandom % 4), 1, -1, -1, -1, "R2 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule